// File: doc/BRIEF.md
# Per-Lane Frame Alignment Monitor

This block sits behind the character decoders of a multi-lane serial converter receiver. It checks where alignment control characters turn up in the decoded octet stream on each lane. A frame-end marker may appear only on the last octet of a frame. A multiframe-end marker may appear only on the last octet of a multiframe. Each marker found anywhere else adds one to a saturating error counter for that lane. The receive framer supplies the frame position, and all lanes share it.

The check runs only when scrambling and monitoring are both switched on, and it pauses while the link is still in code group synchronization. Each lane's counter is compared against a programmable threshold. When any enabled lane reaches the threshold, a sticky interrupt is set for software. If the automatic reset option is on, a link reset request is set at the same time. A single write-one-to-clear pulse clears the interrupt, the reset request and every counter.

Top module: `fam_monitor`

## Requirements
- R1: After reset all lane counters read 0, and `irq` and `link_reset_req` are 0.
- R2: A control octet of value 0xFC (frame-end marker) that arrives while `pos_eof` is 0 adds one to that lane's counter, visible on `lane_err_cnt` after the next clock edge. The same octet with `pos_eof` at 1 adds nothing.
- R3: A control octet of value 0x7C (multiframe-end marker) that arrives while `pos_eomf` is 0 adds one to that lane's counter. The same octet with `pos_eomf` at 1 adds nothing.
- R4: Counters change only when `cfg_scramble_en` and `cfg_mon_en` are both 1. If either is 0, markers are ignored.
- R5: While `in_cgs` is 1, no counter increments.
- R6: An octet whose control flag is 0 is never counted, even if its value is 0xFC or 0x7C. A control octet with any other value (for example 0xBC) is never counted.
- R7: A counter that has reached 2^CNT_W-1 holds that value on further errors and does not wrap.
- R8: `lane_over[i]` is 1 exactly when counter i is at least `cfg_threshold` and `cfg_threshold` is nonzero. A threshold of 0 disables the comparison.
- R9: `irq` rises one clock after any lane has `lane_over` at 1 while its bit in `cfg_lane_en` is 1. Once set, it stays at 1 until cleared.
- R10: A lane whose `cfg_lane_en` bit is 0 never causes `irq`, whatever its count.
- R11: A one-cycle `irq_clr` pulse zeroes all counters, `irq` and `link_reset_req` at the next edge. The clear takes priority over an error or a threshold hit in the same cycle.
- R12: `link_reset_req` is set together with `irq` only when `cfg_auto_reset` is 1. With `cfg_auto_reset` at 0, which is the expected reset value of that configuration bit, it stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive link clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_octet | input | NUM_LANES*8 | Decoded octet per lane, lane i at bits [8i+7:8i] |
| lane_is_ctrl | input | NUM_LANES | Control-character flag per lane |
| pos_eof | input | 1 | Current octet is the last of a frame |
| pos_eomf | input | 1 | Current octet is the last of a multiframe |
| in_cgs | input | 1 | Link still in code group synchronization |
| cfg_scramble_en | input | 1 | Scrambling is enabled on the link |
| cfg_mon_en | input | 1 | Alignment monitoring enabled |
| cfg_auto_reset | input | 1 | Request a link reset when the threshold is reached |
| cfg_threshold | input | CNT_W | Error threshold; 0 disables the comparison |
| cfg_lane_en | input | NUM_LANES | Lane enable mask for interrupt generation |
| irq_clr | input | 1 | Write-one-to-clear pulse for the interrupt and counters |
| irq | output | 1 | Sticky misalignment interrupt |
| link_reset_req | output | 1 | Sticky link reset request |
| lane_err_cnt | output | NUM_LANES*CNT_W | Per-lane error counters |
| lane_over | output | NUM_LANES | Per-lane threshold reached |

## Verification
The assertions assume that `irq_clr` is a single-cycle pulse. They also assume that the framer raises `pos_eof` whenever it raises `pos_eomf`, and that the configuration inputs change only between test steps. The bench drives every input on the falling clock edge and keeps the configuration steady within each scenario. It always raises the multiframe position together with the frame position, so a marker that is correctly placed at a multiframe end is never also counted as a frame error.

// File: rtl/fam_pkg.sv
package fam_pkg;
    // Control character codes checked by the monitor
    localparam logic [7:0] K_FRAME_END = 8'hFC;
    localparam logic [7:0] K_MFRAME_END = 8'h7C;

    typedef struct packed {
        logic irq;
        logic rst_req;
    } fam_irq_state_t;
endpackage

// File: rtl/fam_lane_check.sv
module fam_lane_check #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       octet,
    input  logic             is_ctrl,
    input  logic             pos_eof,
    input  logic             pos_eomf,
    input  logic             active,
    input  logic             clr,
    input  logic [CNT_W-1:0] thr,
    output logic [CNT_W-1:0] cnt,
    output logic             over
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } lane_state_t;

    lane_state_t st_d, st_q;
    logic fmark_bad, mfmark_bad, err;

    always_comb begin
        fmark_bad  = is_ctrl && (octet == fam_pkg::K_FRAME_END) && !pos_eof;
        mfmark_bad = is_ctrl && (octet == fam_pkg::K_MFRAME_END) && !pos_eomf;
        err        = active && (fmark_bad || mfmark_bad);
        st_d       = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else if (err && (st_q.cnt != CNT_MAX)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt  = st_q.cnt;
    assign over = (thr != '0) && (st_q.cnt >= thr);

    // R7: saturated counter never wraps
    a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == CNT_MAX && !clr) |=> (st_q.cnt == CNT_MAX));
    // R4: counter frozen while checking is inactive
    a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !clr) |=> $stable(st_q.cnt));
    // R11: clear empties the counter
    a_r11_lane_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.cnt == '0));
    // R2: at most one error counted per cycle
    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (st_q.cnt == $past(st_q.cnt) || st_q.cnt == $past(st_q.cnt) + 1'b1));
endmodule

// File: rtl/fam_irq_ctrl.sv
module fam_irq_ctrl #(
    parameter int NUM_LANES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LANES-1:0] hit,
    input  logic [NUM_LANES-1:0] lane_en,
    input  logic                 auto_reset,
    input  logic                 clr,
    output logic                 irq,
    output logic                 rst_req
);
    fam_pkg::fam_irq_state_t st_d, st_q;
    logic any_hit;

    always_comb begin
        any_hit = |(hit & lane_en);
        st_d    = st_q;
        if (clr) begin
            st_d = '0;
        end else if (any_hit) begin
            st_d.irq = 1'b1;
            if (auto_reset) st_d.rst_req = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq     = st_q.irq;
    assign rst_req = st_q.rst_req;

    // R9: interrupt is sticky until cleared
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.irq && !clr) |=> st_q.irq);
    // R11: clear drops interrupt and request
    a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!st_q.irq && !st_q.rst_req));
    // R10: no enabled hit keeps a quiet interrupt quiet
    a_r10_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|(hit & lane_en)) && !st_q.irq) |=> !st_q.irq);
    // R12: reset request only accompanies the interrupt
    a_r12_req_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rst_req |-> st_q.irq);
    // R12: manual mode never raises a request
    a_r12_manual: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_reset && !st_q.rst_req) |=> !st_q.rst_req);
endmodule

// File: rtl/fam_monitor.sv
module fam_monitor #(
    parameter int NUM_LANES = 4,
    parameter int CNT_W     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_LANES*8-1:0]     lane_octet,
    input  logic [NUM_LANES-1:0]       lane_is_ctrl,
    input  logic                       pos_eof,
    input  logic                       pos_eomf,
    input  logic                       in_cgs,
    input  logic                       cfg_scramble_en,
    input  logic                       cfg_mon_en,
    input  logic                       cfg_auto_reset,
    input  logic [CNT_W-1:0]           cfg_threshold,
    input  logic [NUM_LANES-1:0]       cfg_lane_en,
    input  logic                       irq_clr,
    output logic                       irq,
    output logic                       link_reset_req,
    output logic [NUM_LANES*CNT_W-1:0] lane_err_cnt,
    output logic [NUM_LANES-1:0]       lane_over
);
    logic check_active;

    assign check_active = cfg_scramble_en && cfg_mon_en && !in_cgs;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        fam_lane_check #(.CNT_W(CNT_W)) lane_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .octet    (lane_octet[g*8 +: 8]),
            .is_ctrl  (lane_is_ctrl[g]),
            .pos_eof  (pos_eof),
            .pos_eomf (pos_eomf),
            .active   (check_active),
            .clr      (irq_clr),
            .thr      (cfg_threshold),
            .cnt      (lane_err_cnt[g*CNT_W +: CNT_W]),
            .over     (lane_over[g])
        );
    end

    fam_irq_ctrl #(.NUM_LANES(NUM_LANES)) irq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit        (lane_over),
        .lane_en    (cfg_lane_en),
        .auto_reset (cfg_auto_reset),
        .clr        (irq_clr),
        .irq        (irq),
        .rst_req    (link_reset_req)
    );

    // R5: counters frozen during code group synchronization
    a_r5_cgs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (in_cgs && !irq_clr) |=> $stable(lane_err_cnt));
endmodule

// File: tb/fam_monitor_tb_top.sv
`timescale 1ns/1ps
module fam_monitor_tb_top;
    localparam int NL = 4;
    localparam int CW = 8;

    logic clk = 1'b0;
    logic rst_n;
    logic [NL*8-1:0]  lane_octet;
    logic [NL-1:0]    lane_is_ctrl;
    logic pos_eof, pos_eomf, in_cgs;
    logic cfg_scramble_en, cfg_mon_en, cfg_auto_reset;
    logic [CW-1:0]    cfg_threshold;
    logic [NL-1:0]    cfg_lane_en;
    logic irq_clr;
    logic irq, link_reset_req;
    logic [NL*CW-1:0] lane_err_cnt;
    logic [NL-1:0]    lane_over;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    fam_monitor #(.NUM_LANES(NL), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .lane_octet(lane_octet), .lane_is_ctrl(lane_is_ctrl),
        .pos_eof(pos_eof), .pos_eomf(pos_eomf), .in_cgs(in_cgs),
        .cfg_scramble_en(cfg_scramble_en), .cfg_mon_en(cfg_mon_en),
        .cfg_auto_reset(cfg_auto_reset), .cfg_threshold(cfg_threshold),
        .cfg_lane_en(cfg_lane_en), .irq_clr(irq_clr), .irq(irq),
        .link_reset_req(link_reset_req), .lane_err_cnt(lane_err_cnt), .lane_over(lane_over)
    );

    task automatic check(string req, int actual, int expected);
        n_checks++;
        if (actual != expected) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    function automatic int cnt_of(int lane);
        return int'(lane_err_cnt[lane*CW +: CW]);
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_in();
        lane_octet   = '0;
        lane_is_ctrl = '0;
        pos_eof      = 1'b0;
        pos_eomf     = 1'b0;
        irq_clr      = 1'b0;
    endtask

    task automatic put(int lane, logic [7:0] code, logic ctrl);
        lane_octet[lane*8 +: 8] = code;
        lane_is_ctrl[lane]      = ctrl;
    endtask

    task automatic do_clear();
        idle_in();
        irq_clr = 1'b1;
        tick();
        irq_clr = 1'b0;
    endtask

    task automatic t_reset();
        for (int l = 0; l < NL; l++) check("R1 count", cnt_of(l), 0);
        check("R1 irq", int'(irq), 0);
        check("R1 req", int'(link_reset_req), 0);
    endtask

    task automatic t_frame_mark();
        idle_in(); put(0, 8'hFC, 1'b1); tick(); idle_in();
        check("R2 misplaced", cnt_of(0), 1);
        put(0, 8'hFC, 1'b1); pos_eof = 1'b1; tick(); idle_in();
        check("R2 at eof", cnt_of(0), 1);
        put(2, 8'hFC, 1'b1); tick(); idle_in();
        check("R2 lane2", cnt_of(2), 1);
        do_clear();
    endtask

    task automatic t_mframe_mark();
        put(1, 8'h7C, 1'b1); pos_eof = 1'b1; tick(); idle_in();
        check("R3 misplaced", cnt_of(1), 1);
        put(1, 8'h7C, 1'b1); pos_eof = 1'b1; pos_eomf = 1'b1; tick(); idle_in();
        check("R3 at eomf", cnt_of(1), 1);
        do_clear();
    endtask

    task automatic t_gates();
        cfg_scramble_en = 1'b0;
        put(0, 8'hFC, 1'b1); tick(); idle_in();
        check("R4 scramble off", cnt_of(0), 0);
        cfg_scramble_en = 1'b1; cfg_mon_en = 1'b0;
        put(0, 8'hFC, 1'b1); tick(); idle_in();
        check("R4 monitor off", cnt_of(0), 0);
        cfg_mon_en = 1'b1;
        put(0, 8'hFC, 1'b1); tick(); idle_in();
        check("R4 both on", cnt_of(0), 1);
        do_clear();
    endtask

    task automatic t_cgs();
        in_cgs = 1'b1;
        put(3, 8'h7C, 1'b1); tick(); idle_in();
        in_cgs = 1'b0;
        check("R5 cgs", cnt_of(3), 0);
    endtask

    task automatic t_data_octet();
        put(0, 8'hFC, 1'b0); put(1, 8'h7C, 1'b0); put(2, 8'hBC, 1'b1); tick(); idle_in();
        check("R6 data FC", cnt_of(0), 0);
        check("R6 data 7C", cnt_of(1), 0);
        check("R6 other K", cnt_of(2), 0);
    endtask

    task automatic t_threshold_irq();
        cfg_threshold = 8'd3;
        for (int k = 0; k < 2; k++) begin put(3, 8'hFC, 1'b1); tick(); idle_in(); end
        check("R8 below", int'(lane_over[3]), 0);
        tick();
        check("R9 no irq below", int'(irq), 0);
        put(3, 8'hFC, 1'b1); tick(); idle_in();
        check("R8 reached", int'(lane_over[3]), 1);
        check("R9 irq one later", int'(irq), 0);
        tick();
        check("R9 irq set", int'(irq), 1);
        repeat (3) tick();
        check("R9 sticky", int'(irq), 1);
        check("R12 manual no req", int'(link_reset_req), 0);
        do_clear();
        check("R11 irq cleared", int'(irq), 0);
        check("R11 count cleared", cnt_of(3), 0);
        cfg_threshold = 8'd0;
        put(3, 8'hFC, 1'b1); tick(); idle_in();
        check("R8 threshold zero", int'(lane_over[3]), 0);
        tick();
        check("R8 zero no irq", int'(irq), 0);
        do_clear();
    endtask

    task automatic t_disabled_lane();
        cfg_threshold = 8'd1; cfg_lane_en = 4'b1110;
        put(0, 8'hFC, 1'b1); tick(); idle_in();
        check("R10 lane over", int'(lane_over[0]), 1);
        tick(); tick();
        check("R10 masked irq", int'(irq), 0);
        do_clear();
        cfg_lane_en = 4'hF;
    endtask

    task automatic t_auto_reset();
        cfg_threshold = 8'd1; cfg_auto_reset = 1'b1;
        put(1, 8'h7C, 1'b1); tick(); idle_in();
        tick();
        check("R12 irq", int'(irq), 1);
        check("R12 req", int'(link_reset_req), 1);
        put(2, 8'hFC, 1'b1); irq_clr = 1'b1; tick(); idle_in();
        check("R11 clear beats error", cnt_of(2), 0);
        check("R11 irq", int'(irq), 0);
        check("R11 req", int'(link_reset_req), 0);
        tick();
        check("R11 stays clear", int'(irq), 0);
        cfg_auto_reset = 1'b0;
    endtask

    task automatic t_saturate();
        cfg_threshold = 8'd0;
        put(0, 8'hFC, 1'b1);
        repeat (260) tick();
        idle_in();
        check("R7 saturate", cnt_of(0), 255);
        tick();
        check("R7 hold", cnt_of(0), 255);
        do_clear();
    endtask

    initial begin
        rst_n = 1'b0;
        idle_in();
        in_cgs = 1'b0; cfg_scramble_en = 1'b1; cfg_mon_en = 1'b1; cfg_auto_reset = 1'b0;
        cfg_threshold = 8'd3; cfg_lane_en = 4'hF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_frame_mark();
        t_mframe_mark();
        t_gates();
        t_cgs();
        t_data_octet();
        t_threshold_irq();
        t_disabled_lane();
        t_auto_reset();
        t_saturate();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule